// File: doc/BRIEF.md
# USB Endpoint Response Selector

This block sits beside the device-side packet engine of a USB function and decides what answer the engine gives each token it receives. It holds one 8-bit control register for each of sixteen endpoints. A plain write port and a combinational read port set and read these registers. Each register marks whether its endpoint may transmit, may receive, is stalled, sends handshakes, and accepts control (SETUP) transfers.

A decoded token arrives as an endpoint number, a token kind and a flag that says whether the endpoint's data buffer is ready. The block picks one of five responses from the current register contents and presents it one clock later. Two extra bits in the endpoint 0 register are settings for host operation. They play no part in the response and are driven straight out as level outputs.

Top module: `usb_ep_responder`

## Requirements
- R1: After reset every endpoint register reads 0x00, `resp_valid` is 0, `resp_code` is 0 (IGNORE) and both host outputs are 0.
- R2: A write with `wr_en` high stores `wr_data` into the register `wr_addr` at the next rising clock edge, and `rd_data` shows the stored value of the register at `rd_addr`. Register fields: bit 0 handshake enable, bit 1 stall, bit 2 transmit enable, bit 3 receive enable, bit 4 SETUP disable, bit 5 reserved, bit 6 retry disable, bit 7 direct low-speed.
- R3: Bit 5 of every register always reads 0, whatever value is written to it.
- R4: Bits 6 and 7 are stored only in the endpoint 0 register and read 0 on endpoints 1 to 15. Endpoint 0 bit 6 drives `host_retry_off` and bit 7 drives `host_direct_ls`.
- R5: For a token sampled with `tok_valid` high at a clock edge, `resp_valid` is 1 and `resp_code` holds the decision after that edge. With no token, `resp_valid` is 0 and `resp_code` is 0. Codes: 0 IGNORE, 1 ACK, 2 NAK, 3 STALL, 4 NO_HANDSHAKE. Token kinds on `tok_type`: 0 OUT, 1 IN, 2 SETUP, 3 unused.
- R6: A token to an endpoint with both transmit enable and receive enable clear gets IGNORE, even if its stall bit is set.
- R7: A token of any kind, including one whose direction is not enabled, to an endpoint with the stall bit set and at least one direction enabled gets STALL.
- R8: On an unstalled enabled endpoint, IN without transmit enable, OUT or SETUP without receive enable, and the unused kind 3 all get IGNORE.
- R9: A SETUP token gets IGNORE when SETUP disable, transmit enable and receive enable are all set. With SETUP disable set and only receive enabled, the SETUP is accepted. OUT and IN are never blocked by this bit.
- R10: An accepted token to an endpoint with handshake enable clear gets NO_HANDSHAKE, whatever the buffer flag is.
- R11: An accepted token to an endpoint with handshake enable set gets ACK when `tok_buf_rdy` is 1 and NAK when it is 0.
- R12: When a write and a token to the same endpoint arrive in one cycle, the token is decided from the register value before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Endpoint register to write |
| wr_data | input | 8 | Value to write |
| rd_addr | input | 4 | Endpoint register to read |
| rd_data | output | 8 | Contents of the register at rd_addr |
| tok_valid | input | 1 | A decoded token is present |
| tok_ep | input | 4 | Endpoint addressed by the token |
| tok_type | input | 2 | Token kind: 0 OUT, 1 IN, 2 SETUP |
| tok_buf_rdy | input | 1 | Endpoint buffer can accept or supply data |
| resp_valid | output | 1 | resp_code holds a decision |
| resp_code | output | 3 | Response: 0 IGNORE, 1 ACK, 2 NAK, 3 STALL, 4 NO_HANDSHAKE |
| host_retry_off | output | 1 | Endpoint 0 bit 6 |
| host_direct_ls | output | 1 | Endpoint 0 bit 7 |

## Verification
The decision is tried against a table of register settings paired with each token kind and both buffer flag values. The table tells the five outcomes apart at every step of the priority order. Some entries set the stall bit with no direction enabled, to separate "stall wins" from "stall only on live endpoints". A single-direction endpoint receives the opposite token, which exposes a missing direction check. SETUP disable is tried with both directions and with receive only, which shows whether the both-directions condition is present. A same-cycle write and token shows whether the decision uses the old contents or the new ones.

// File: rtl/usb_ep_pkg.sv
package usb_ep_pkg;

    localparam int CTL_W = 8;

    typedef enum logic [1:0] {
        TOK_OUT   = 2'd0,
        TOK_IN    = 2'd1,
        TOK_SETUP = 2'd2,
        TOK_NONE  = 2'd3
    } tok_e;

    typedef enum logic [2:0] {
        RSP_IGNORE = 3'd0,
        RSP_ACK    = 3'd1,
        RSP_NAK    = 3'd2,
        RSP_STALL  = 3'd3,
        RSP_NOHS   = 3'd4
    } rsp_e;

    // field order is msb first; bit positions are visible to software
    typedef struct packed {
        logic direct_ls;   // bit 7, endpoint 0 only
        logic retry_off;   // bit 6, endpoint 0 only
        logic rsvd;        // bit 5, reads zero
        logic setup_off;   // bit 4
        logic rx_en;       // bit 3
        logic tx_en;       // bit 2
        logic stall;       // bit 1
        logic hs_en;       // bit 0
    } ep_ctl_t;

    localparam logic [CTL_W-1:0] KEEP_EP0 = 8'hDF;
    localparam logic [CTL_W-1:0] KEEP_EPN = 8'h1F;

endpackage

// File: rtl/ep_ctl_bank.sv
module ep_ctl_bank
    import usb_ep_pkg::*;
#(
    parameter int NUM_EP = 16,
    localparam int AW = $clog2(NUM_EP)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [CTL_W-1:0]  wr_data,
    input  logic [AW-1:0]     rd_addr,
    output logic [CTL_W-1:0]  rd_data,
    input  logic [AW-1:0]     tok_ep,
    output ep_ctl_t           tok_ctl,
    output ep_ctl_t           ep0_ctl
);

    ep_ctl_t          regs_d [NUM_EP];
    ep_ctl_t          regs_q [NUM_EP];
    logic [CTL_W-1:0] keep   [NUM_EP];

    // endpoint 0 keeps the host bits, the rest drop them
    for (genvar g = 0; g < NUM_EP; g++) begin : g_keep
        if (g == 0) begin : g_ep0
            assign keep[g] = KEEP_EP0;
        end else begin : g_epn
            assign keep[g] = KEEP_EPN;
        end
    end

    always_comb begin
        for (int i = 0; i < NUM_EP; i++) begin
            regs_d[i] = regs_q[i];
            if (wr_en && (int'(wr_addr) == i)) begin
                regs_d[i] = ep_ctl_t'(wr_data & keep[i]);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_EP; i++) begin
                regs_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < NUM_EP; i++) begin
                regs_q[i] <= regs_d[i];
            end
        end
    end

    always_comb begin
        rd_data = '0;
        tok_ctl = '0;
        if (int'(rd_addr) < NUM_EP) begin
            rd_data = regs_q[rd_addr];
        end
        if (int'(tok_ep) < NUM_EP) begin
            tok_ctl = regs_q[tok_ep];
        end
    end

    assign ep0_ctl = regs_q[0];

endmodule

// File: rtl/ep_rsp_decide.sv
module ep_rsp_decide
    import usb_ep_pkg::*;
(
    input  ep_ctl_t ctl,
    input  tok_e    kind,
    input  logic    buf_rdy,
    output rsp_e    rsp
);

    logic live;
    logic dir_ok;
    logic setup_blocked;
    logic unused_bits;

    assign unused_bits = ^{ctl.direct_ls, ctl.retry_off, ctl.rsvd};

    always_comb begin
        live = ctl.tx_en | ctl.rx_en;
        unique case (kind)
            TOK_IN:    dir_ok = ctl.tx_en;
            TOK_OUT:   dir_ok = ctl.rx_en;
            TOK_SETUP: dir_ok = ctl.rx_en;
            default:   dir_ok = 1'b0;
        endcase
        setup_blocked = (kind == TOK_SETUP) && ctl.setup_off
                        && ctl.tx_en && ctl.rx_en;

        if (!live) begin
            rsp = RSP_IGNORE;
        end else if (ctl.stall) begin
            rsp = RSP_STALL;
        end else if (!dir_ok || setup_blocked) begin
            rsp = RSP_IGNORE;
        end else if (!ctl.hs_en) begin
            rsp = RSP_NOHS;
        end else if (buf_rdy) begin
            rsp = RSP_ACK;
        end else begin
            rsp = RSP_NAK;
        end
    end

endmodule

// File: rtl/ep_rsp_stage.sv
module ep_rsp_stage
    import usb_ep_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    input  rsp_e in_rsp,
    output logic out_valid,
    output rsp_e out_rsp
);

    typedef struct packed {
        logic valid;
        rsp_e code;
    } stage_t;

    stage_t st_d;
    stage_t st_q;

    always_comb begin
        st_d.valid = in_valid;
        st_d.code  = in_valid ? in_rsp : RSP_IGNORE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{valid: 1'b0, code: RSP_IGNORE};
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.valid;
    assign out_rsp   = st_q.code;

endmodule

// File: rtl/usb_ep_responder.sv
module usb_ep_responder
    import usb_ep_pkg::*;
#(
    parameter int NUM_EP = 16,
    localparam int AW = $clog2(NUM_EP)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [CTL_W-1:0] wr_data,
    input  logic [AW-1:0]    rd_addr,
    output logic [CTL_W-1:0] rd_data,
    input  logic             tok_valid,
    input  logic [AW-1:0]    tok_ep,
    input  logic [1:0]       tok_type,
    input  logic             tok_buf_rdy,
    output logic             resp_valid,
    output logic [2:0]       resp_code,
    output logic             host_retry_off,
    output logic             host_direct_ls
);

    ep_ctl_t tok_ctl;
    ep_ctl_t ep0_ctl;
    rsp_e    rsp_now;
    rsp_e    rsp_reg;

    ep_ctl_bank #(.NUM_EP(NUM_EP)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .tok_ep  (tok_ep),
        .tok_ctl (tok_ctl),
        .ep0_ctl (ep0_ctl)
    );

    ep_rsp_decide u_decide (
        .ctl     (tok_ctl),
        .kind    (tok_e'(tok_type)),
        .buf_rdy (tok_buf_rdy),
        .rsp     (rsp_now)
    );

    ep_rsp_stage u_stage (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (tok_valid),
        .in_rsp    (rsp_now),
        .out_valid (resp_valid),
        .out_rsp   (rsp_reg)
    );

    assign resp_code      = rsp_reg;
    assign host_retry_off = ep0_ctl.retry_off;
    assign host_direct_ls = ep0_ctl.direct_ls;

endmodule

// File: rtl/usb_ep_responder_chk.sv
module usb_ep_responder_chk #(
    parameter int AW = 4
) (
    input logic         clk,
    input logic         rst_n,
    input logic         wr_en,
    input logic [AW-1:0] wr_addr,
    input logic [7:0]   wr_data,
    input logic [AW-1:0] rd_addr,
    input logic [7:0]   rd_data,
    input logic         tok_valid,
    input logic         resp_valid,
    input logic [2:0]   resp_code,
    input logic         host_retry_off,
    input logic         host_direct_ls
);

    a_r3_rsvd_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[5] == 1'b0);

    a_r4_host_bits_ep0_only: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr != '0) |-> (rd_data[7:6] == 2'b00));

    a_r4_host_bits_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_addr == '0) |=> $stable({host_direct_ls, host_retry_off}));

    a_r4_host_bits_load: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == '0) |=>
            ({host_direct_ls, host_retry_off} == $past(wr_data[7:6])));

    a_r5_token_gives_resp: assert property (@(posedge clk) disable iff (!rst_n)
        tok_valid |=> resp_valid);

    a_r5_no_token_no_resp: assert property (@(posedge clk) disable iff (!rst_n)
        !tok_valid |=> !resp_valid);

    a_r5_idle_code_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !resp_valid |-> (resp_code == 3'd0));

    a_r5_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
        resp_code <= 3'd4);

endmodule

bind usb_ep_responder usb_ep_responder_chk #(.AW(AW)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .wr_en          (wr_en),
    .wr_addr        (wr_addr),
    .wr_data        (wr_data),
    .rd_addr        (rd_addr),
    .rd_data        (rd_data),
    .tok_valid      (tok_valid),
    .resp_valid     (resp_valid),
    .resp_code      (resp_code),
    .host_retry_off (host_retry_off),
    .host_direct_ls (host_direct_ls)
);

// File: tb/sim_usb_ep_responder.sv
`timescale 1ns/1ps
module sim_usb_ep_responder;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       wr_en;
    logic [3:0] wr_addr;
    logic [7:0] wr_data;
    logic [3:0] rd_addr;
    logic [7:0] rd_data;
    logic       tok_valid;
    logic [3:0] tok_ep;
    logic [1:0] tok_type;
    logic       tok_buf_rdy;
    logic       resp_valid;
    logic [2:0] resp_code;
    logic       host_retry_off;
    logic       host_direct_ls;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    usb_ep_responder u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .tok_valid(tok_valid), .tok_ep(tok_ep), .tok_type(tok_type),
        .tok_buf_rdy(tok_buf_rdy), .resp_valid(resp_valid),
        .resp_code(resp_code), .host_retry_off(host_retry_off),
        .host_direct_ls(host_direct_ls)
    );

    // token kinds: 0 OUT, 1 IN, 2 SETUP, 3 unused
    // responses: 0 IGNORE, 1 ACK, 2 NAK, 3 STALL, 4 NO_HANDSHAKE
    // entry: {register, kind, buffer ready, expected response}
    localparam int NV = 16;
    localparam logic [13:0] VEC [NV] = '{
        {8'h00, 2'd0, 1'b1, 3'd0},   // R6 nothing enabled
        {8'h02, 2'd1, 1'b1, 3'd0},   // R6 stall on dead endpoint
        {8'h0D, 2'd0, 1'b1, 3'd1},   // R11 ack
        {8'h0D, 2'd1, 1'b0, 3'd2},   // R11 nak
        {8'h0D, 2'd2, 1'b1, 3'd1},   // R11 setup ack
        {8'h05, 2'd0, 1'b1, 3'd0},   // R8 OUT without rx
        {8'h09, 2'd1, 1'b1, 3'd0},   // R8 IN without tx
        {8'h09, 2'd2, 1'b0, 3'd2},   // R11 setup nak
        {8'h06, 2'd0, 1'b1, 3'd3},   // R7 stall, wrong direction
        {8'h0F, 2'd2, 1'b1, 3'd3},   // R7 stall setup
        {8'h1D, 2'd2, 1'b1, 3'd0},   // R9 setup blocked
        {8'h19, 2'd2, 1'b1, 3'd1},   // R9 rx only, setup allowed
        {8'h1D, 2'd0, 1'b1, 3'd1},   // R9 OUT unaffected
        {8'h0C, 2'd1, 1'b1, 3'd4},   // R10 no handshake
        {8'h0C, 2'd0, 1'b0, 3'd4},   // R10 no handshake, not ready
        {8'h0D, 2'd3, 1'b1, 3'd0}    // R8 unused kind
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [3:0] ep, input logic [7:0] val);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = ep; wr_data = val;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic reg_read(input logic [3:0] ep, output logic [7:0] val);
        rd_addr = ep;
        #1;
        val = rd_data;
    endtask

    task automatic send_tok(input logic [3:0] ep, input logic [1:0] kind,
                            input logic rdy, output logic [2:0] rsp, output logic vld);
        @(negedge clk);
        tok_valid = 1'b1; tok_ep = ep; tok_type = kind; tok_buf_rdy = rdy;
        @(negedge clk);
        rsp = resp_code; vld = resp_valid;
        tok_valid = 1'b0;
    endtask

    initial begin
        #500000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] rv;
        logic [2:0] rsp;
        logic       vld;

        rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
        tok_valid = 1'b0; tok_ep = '0; tok_type = '0; tok_buf_rdy = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int e = 0; e < 16; e++) begin
            reg_read(4'(e), rv);
            chk("R1 reg after reset", rv, 8'h00);
        end
        chk("R1 resp_valid", {7'b0, resp_valid}, 8'h00);
        chk("R1 resp_code", {5'b0, resp_code}, 8'h00);
        chk("R1 host bits", {6'b0, host_direct_ls, host_retry_off}, 8'h00);

        // table walk, each entry on its own endpoint 1..15 or 0
        for (int i = 0; i < NV; i++) begin
            logic [3:0] ep;
            ep = 4'(i);
            reg_write(ep, VEC[i][13:6]);
            send_tok(ep, VEC[i][5:4], VEC[i][3], rsp, vld);
            chk("R5 resp_valid on token", {7'b0, vld}, 8'h01);
            chk("R6 R7 R8 R9 R10 R11 table response", {5'b0, rsp}, {5'b0, VEC[i][2:0]});
        end

        // R2 write and read back
        reg_write(4'd7, 8'h1A);
        reg_read(4'd7, rv);
        chk("R2 readback", rv, 8'h1A);

        // R3 reserved bit
        reg_write(4'd3, 8'hFF);
        reg_read(4'd3, rv);
        chk("R3 R4 ep3 write all ones", rv, 8'h1F);
        reg_write(4'd3, 8'h20);
        reg_read(4'd3, rv);
        chk("R3 reserved only", rv, 8'h00);

        // R4 endpoint 0 host bits
        reg_write(4'd0, 8'hFF);
        reg_read(4'd0, rv);
        chk("R4 ep0 readback", rv, 8'hDF);
        chk("R4 host outputs set", {6'b0, host_direct_ls, host_retry_off}, 8'h03);
        reg_write(4'd0, 8'h40);
        chk("R4 host outputs split", {6'b0, host_direct_ls, host_retry_off}, 8'h01);
        reg_write(4'd9, 8'hC0);
        chk("R4 other ep write leaves host bits", {6'b0, host_direct_ls, host_retry_off}, 8'h01);
        reg_read(4'd9, rv);
        chk("R4 ep9 high bits dropped", rv, 8'h00);

        // R12 same-cycle write and token
        reg_write(4'd5, 8'h0D);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 4'd5; wr_data = 8'h0F;
        tok_valid = 1'b1; tok_ep = 4'd5; tok_type = 2'd1; tok_buf_rdy = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        chk("R12 decided on old value", {5'b0, resp_code}, 8'h01);
        @(negedge clk);
        tok_valid = 1'b0;
        chk("R12 new value next token", {5'b0, resp_code}, 8'h03);

        // R5 idle after token
        @(negedge clk);
        chk("R5 idle valid", {7'b0, resp_valid}, 8'h00);
        chk("R5 idle code", {5'b0, resp_code}, 8'h00);

        // R11 same endpoint, flag toggles
        send_tok(4'd2, 2'd0, 1'b0, rsp, vld);
        chk("R11 nak with buffer busy", {5'b0, rsp}, 8'h02);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule